// File: doc/BRIEF.md
# USB Device Interrupt Status Register

This block collects interrupt causes for a USB device controller into one 32-bit sticky status register. Each endpoint presents its level control and status flags. The block keeps a registered copy of those flags, finds the transitions that matter for that endpoint's transfer type, and sets that endpoint's status bit. A separate bus monitor delivers single-cycle pulses for suspend, resume, bus reset and disconnect. Each of these pulses sets its own status bit.

A processor reads two words: the status word and an enable mask. It clears status bits by writing ones to them. A parameter fixes each endpoint as control, bulk or isochronous. One level interrupt output is asserted while any enabled status bit is set.

Top module: `usb_irq_status`

## Requirements
- R1: After reset the status word reads 0, the enable word reads 0x00000E1F (every defined source enabled except suspend, bit 8), and irq_o is low.
- R2: A control endpoint (endpoint 0 by default, status bit 0) sets its bit on any of the following: out_rdy rising, stall_in or stall_out rising, setup_end rising, in_rdy falling, or data_end falling.
- R3: A bulk endpoint (endpoints 1 and 2 by default, status bits 1 and 2) sets its bit on any of the following: in_rdy falling, a flush pulse, or stall_in or stall_out rising. A rise of out_rdy has no effect on a bulk endpoint.
- R4: An isochronous endpoint (endpoints 3 and 4 by default, status bits 3 and 4) sets its bit on the bulk conditions and also on underrun rising. A rise of out_rdy has no effect on an isochronous endpoint.
- R5: A pulse on susp_i sets bit 8. A pulse on resume_i sets bit 9. A pulse on bus_rst_i sets bit 10. A pulse on discon_i sets bit 11.
- R6: A write with sel_i=0 clears each status bit whose wdata bit is 1. Status bits whose wdata bit is 0 are left unchanged.
- R7: No write can set a status bit.
- R8: If a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Reserved bits (7:5 and 31:12) read 0 in both words, and writes to them are ignored.
- R10: A write with sel_i=1 loads the enable word. irq_o is the OR, over all status bits, of each status bit ANDed with its enable bit.
- R11: A flag change or pulse that is present before a rising clock edge shows up in the status word at that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_rdy_i | input | NUM_EP | Per-endpoint out-packet-ready flag |
| in_rdy_i | input | NUM_EP | Per-endpoint in-packet-ready flag |
| stall_in_i | input | NUM_EP | Per-endpoint sent-stall flag, in direction |
| stall_out_i | input | NUM_EP | Per-endpoint sent-stall flag, out direction |
| setup_end_i | input | NUM_EP | Per-endpoint setup-end flag |
| data_end_i | input | NUM_EP | Per-endpoint data-end flag |
| underrun_i | input | NUM_EP | Per-endpoint in-underrun flag |
| flush_i | input | NUM_EP | Per-endpoint FIFO flush pulse |
| susp_i | input | 1 | Suspend detected pulse |
| resume_i | input | 1 | Resume detected pulse |
| bus_rst_i | input | 1 | Bus reset detected pulse |
| discon_i | input | 1 | Disconnect finished pulse |
| sel_i | input | 1 | Word select: 0 selects status, 1 selects enable |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word (combinational) |
| irq_o | output | 1 | Combined interrupt |

## Verification
Every source passes through exactly one register edge. A flag change or pulse is driven just after a falling edge, and the status word is checked at the next falling edge. For the latency checks, the status word is also checked just before the rising edge, where it must still be clear. A write clears or loads at the rising edge where wr_i is sampled high. irq_o and rdata_o are combinational from the registers, so they are checked at the same falling edge as the status they depend on. A condition that must not fire is checked at that same point, when a wrongly set bit would already be visible.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam logic [1:0] EP_CTRL = 2'd0;
  localparam logic [1:0] EP_BULK = 2'd1;
  localparam logic [1:0] EP_ISO  = 2'd2;

  // flag vector bit order: out_rdy, in_rdy, stall_in, stall_out, setup_end, data_end, underrun
  localparam int unsigned NFLAG = 7;

  function automatic logic [NFLAG-1:0] rise_mask(input logic [1:0] kind);
    case (kind)
      EP_CTRL: rise_mask = 7'b0011101;
      EP_BULK: rise_mask = 7'b0001100;
      default: rise_mask = 7'b1001100;
    endcase
  endfunction

  function automatic logic [NFLAG-1:0] fall_mask(input logic [1:0] kind);
    case (kind)
      EP_CTRL: fall_mask = 7'b0100010;
      default: fall_mask = 7'b0000010;
    endcase
  endfunction

  function automatic logic flush_en(input logic [1:0] kind);
    flush_en = (kind != EP_CTRL);
  endfunction
endpackage

// File: rtl/usb_ep_event.sv
module usb_ep_event
  import usb_irq_pkg::*;
#(
  parameter logic [1:0] KIND = EP_BULK
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_rdy_i,
  input  logic in_rdy_i,
  input  logic stall_in_i,
  input  logic stall_out_i,
  input  logic setup_end_i,
  input  logic data_end_i,
  input  logic underrun_i,
  input  logic flush_i,
  output logic event_o
);
  localparam logic [NFLAG-1:0] RISE_M = rise_mask(KIND);
  localparam logic [NFLAG-1:0] FALL_M = fall_mask(KIND);
  localparam logic             FLUSH_M = flush_en(KIND);

  logic [NFLAG-1:0] flag, flag_q, rise, fall;

  assign flag = {underrun_i, data_end_i, setup_end_i, stall_out_i,
                 stall_in_i, in_rdy_i, out_rdy_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag;
  end

  assign rise = flag & ~flag_q;
  assign fall = ~flag & flag_q;

  assign event_o = (|(rise & RISE_M)) | (|(fall & FALL_M)) | (flush_i & FLUSH_M);
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs #(
  parameter int unsigned      DW       = 32,
  parameter logic [DW-1:0]    VALID_M  = 32'h0000_0F1F,
  parameter logic [DW-1:0]    EN_RESET = 32'h0000_0E1F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [DW-1:0] status_q, enable_q, clr, status_d;
  logic          wr_stat, wr_en;

  assign wr_stat  = wr_i & ~sel_i;
  assign wr_en    = wr_i & sel_i;
  assign clr      = wr_stat ? wdata_i : '0;
  // set dominates a same-cycle clear
  assign status_d = ((status_q & ~clr) | set_i) & VALID_M;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= EN_RESET & VALID_M;
    end else begin
      status_q <= status_d;
      if (wr_en) enable_q <= wdata_i & VALID_M;
    end
  end

  assign rdata_o = sel_i ? enable_q : status_q;
  assign irq_o   = |(status_q & enable_q);

  a_r7_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~$past(status_q)) & ~$past(set_i)) == '0);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & VALID_M) != '0 |=> (status_q & $past(set_i & VALID_M)) == $past(set_i & VALID_M));

  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> (status_q & $past(wdata_i) & ~$past(set_i)) == '0);

  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q | enable_q) & ~VALID_M) == '0);

  a_r10_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_i) |=> irq_o);
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
  import usb_irq_pkg::*;
#(
  parameter int unsigned          NUM_EP      = 5,   // at most 8
  parameter logic [2*NUM_EP-1:0]  EP_KIND_MAP = 10'b10_10_01_01_00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] out_rdy_i,
  input  logic [NUM_EP-1:0] in_rdy_i,
  input  logic [NUM_EP-1:0] stall_in_i,
  input  logic [NUM_EP-1:0] stall_out_i,
  input  logic [NUM_EP-1:0] setup_end_i,
  input  logic [NUM_EP-1:0] data_end_i,
  input  logic [NUM_EP-1:0] underrun_i,
  input  logic [NUM_EP-1:0] flush_i,
  input  logic              susp_i,
  input  logic              resume_i,
  input  logic              bus_rst_i,
  input  logic              discon_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned DW      = 32;
  localparam int unsigned BUS_LSB = 8;
  localparam logic [DW-1:0] EP_M    = (DW'(1) << NUM_EP) - DW'(1);
  localparam logic [DW-1:0] VALID_M = EP_M | (DW'(4'hF) << BUS_LSB);
  localparam logic [DW-1:0] EN_RST  = VALID_M & ~(DW'(1) << BUS_LSB);

  logic [NUM_EP-1:0] ep_evt;
  logic [DW-1:0]     set_vec;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    usb_ep_event #(.KIND(EP_KIND_MAP[2*i +: 2])) i_evt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .out_rdy_i   (out_rdy_i[i]),
      .in_rdy_i    (in_rdy_i[i]),
      .stall_in_i  (stall_in_i[i]),
      .stall_out_i (stall_out_i[i]),
      .setup_end_i (setup_end_i[i]),
      .data_end_i  (data_end_i[i]),
      .underrun_i  (underrun_i[i]),
      .flush_i     (flush_i[i]),
      .event_o     (ep_evt[i])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[NUM_EP-1:0]       = ep_evt;
    set_vec[BUS_LSB +: 4]     = {discon_i, bus_rst_i, resume_i, susp_i};
  end

  usb_irq_regs #(.DW(DW), .VALID_M(VALID_M), .EN_RESET(EN_RST)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/test_usb_irq_status.sv
module test_usb_irq_status;
  localparam int N = 5;
  logic clk = 0, rst_ni = 0;
  logic [N-1:0] out_rdy = '0, in_rdy = '0, st_in = '0, st_out = '0;
  logic [N-1:0] setup_end = '0, data_end = '0, underrun = '0, flush = '0;
  logic susp = 0, resume = 0, bus_rst = 0, discon = 0;
  logic sel = 0, wr = 0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_irq_status i_usb_irq_status (
    .clk_i(clk), .rst_ni(rst_ni), .out_rdy_i(out_rdy), .in_rdy_i(in_rdy),
    .stall_in_i(st_in), .stall_out_i(st_out), .setup_end_i(setup_end),
    .data_end_i(data_end), .underrun_i(underrun), .flush_i(flush),
    .susp_i(susp), .resume_i(resume), .bus_rst_i(bus_rst), .discon_i(discon),
    .sel_i(sel), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    sel = s; #1; v = rdata; sel = 0;
  endtask

  task automatic wrw(input logic s, input logic [31:0] d);
    sel = s; wr = 1; wdata = d; step(); wr = 0; sel = 0; wdata = '0;
  endtask

  task automatic clr_all();
    wrw(0, 32'hFFFF_FFFF);
  endtask

  task automatic chk_stat(string tag, logic [31:0] exp);
    logic [31:0] v;
    rd(0, v); chk(tag, v, exp);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk_stat("R1 status", 0);
    rd(1, v); chk("R1 enable", v, 32'h0000_0E1F);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    out_rdy[0] = 1; rd(0, v); chk("R11 before edge", v, 0);
    step(); chk_stat("R2 out_rdy rise", 32'h1); clr_all();
    out_rdy[0] = 0; step(); chk_stat("R2 out_rdy fall none", 0);
    in_rdy[0] = 1; step(); chk_stat("R2 in_rdy rise none", 0);
    in_rdy[0] = 0; step(); chk_stat("R2 in_rdy fall", 32'h1); clr_all();
    st_in[0] = 1; step(); chk_stat("R2 stall rise", 32'h1); st_in[0] = 0; clr_all();
    setup_end[0] = 1; step(); chk_stat("R2 setup_end rise", 32'h1); setup_end[0] = 0; clr_all();
    data_end[0] = 1; step(); chk_stat("R2 data_end rise none", 0);
    data_end[0] = 0; step(); chk_stat("R2 data_end fall", 32'h1); clr_all();
    flush[0] = 1; step(); flush[0] = 0; chk_stat("R2 flush none", 0);
  endtask

  task automatic t_bulk();
    out_rdy[1] = 1; step(); chk_stat("R3 out_rdy none", 0); out_rdy[1] = 0; step();
    in_rdy[1] = 1; step(); chk_stat("R3 in_rdy rise none", 0);
    in_rdy[1] = 0; step(); chk_stat("R3 in_rdy fall", 32'h2); clr_all();
    flush[2] = 1; step(); flush[2] = 0; chk_stat("R3 flush", 32'h4); clr_all();
    st_out[1] = 1; step(); chk_stat("R3 stall_out rise", 32'h2); st_out[1] = 0; clr_all();
    underrun[1] = 1; step(); chk_stat("R3 underrun none", 0); underrun[1] = 0; step();
  endtask

  task automatic t_iso();
    logic [31:0] v;
    underrun[3] = 1; rd(0, v); chk("R11 iso before edge", v, 0);
    step(); chk_stat("R4 underrun rise", 32'h8); underrun[3] = 0; clr_all();
    out_rdy[4] = 1; step(); chk_stat("R4 out_rdy none", 0); out_rdy[4] = 0; step();
    in_rdy[4] = 1; step(); in_rdy[4] = 0; step(); chk_stat("R4 in_rdy fall", 32'h10); clr_all();
    flush[4] = 1; step(); flush[4] = 0; chk_stat("R4 flush", 32'h10); clr_all();
  endtask

  task automatic t_bus();
    susp = 1; step(); susp = 0; chk_stat("R5 suspend", 32'h100);
    chk("R10 suspend masked", {31'b0, irq}, 0); clr_all();
    resume = 1; step(); resume = 0; chk_stat("R5 resume", 32'h200);
    chk("R10 resume irq", {31'b0, irq}, 1); clr_all();
    bus_rst = 1; step(); bus_rst = 0; chk_stat("R5 bus reset", 32'h400); clr_all();
    discon = 1; step(); discon = 0; chk_stat("R5 disconnect", 32'h800); clr_all();
  endtask

  task automatic t_w1c();
    resume = 1; flush[1] = 1; step(); resume = 0; flush[1] = 0;
    chk_stat("R6 setup", 32'h202);
    wrw(0, 32'h0000_0002); chk_stat("R6 partial clear", 32'h200);
    wrw(0, 32'h0); chk_stat("R6 zero write", 32'h200);
    clr_all(); chk_stat("R6 full clear", 0);
  endtask

  task automatic t_noset();
    wrw(0, 32'hFFFF_FFFF); chk_stat("R7 write no set", 0);
    chk("R7 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_set_wins();
    resume = 1; step(); resume = 0; chk_stat("R8 setup", 32'h200);
    resume = 1; sel = 0; wr = 1; wdata = 32'h200; step();
    resume = 0; wr = 0; wdata = '0;
    chk_stat("R8 set over clear", 32'h200); clr_all();
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wrw(1, 32'hFFFF_FFFF); rd(1, v); chk("R9 enable reserved", v, 32'h0000_0F1F);
    susp = 1; step(); susp = 0; chk("R10 suspend enabled irq", {31'b0, irq}, 1);
    wrw(1, 32'h0); chk("R10 all masked irq", {31'b0, irq}, 0);
    chk_stat("R10 status kept", 32'h100);
    wrw(1, 32'h100); chk("R10 reenabled irq", {31'b0, irq}, 1);
    clr_all(); chk("R10 cleared irq", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_bulk();
    t_iso();
    t_bus();
    t_w1c();
    t_noset();
    t_set_wins();
    t_enable();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule